// File: doc/BRIEF.md
# Crossing Number Synchronization Checker

This block guards the alignment between two crossing counters that run a fixed trigger latency apart. Locally it counts beam crossings as a bunch number and a turn count. At each crossing it takes a compact identifier of that crossing and pushes it into a shift register whose depth equals the trigger latency, measured in crossings. When a level-1 accept arrives with its composite accept number, the identifier that has just reached the end of the shift register should name the same crossing. If it does not, either the trigger's counters have slipped or the front-end buffering has lost its alignment.

A mismatch produces a one-cycle error pulse that can be sent back toward the trigger framework. It also sets a sticky flag that holds until it is cleared. The mismatching expected and received numbers are latched so they can be read out later. The turn marker input forces the local count back into step at the start of a turn.

Top module: `xsync_checker`

## Requirements
- R1: While reset is asserted, and after reset until the first mismatch, errPulse and errSticky are 0 and expSeen and gotSeen are 0.
- R2: At each cycle with xingStb high, the block captures the identifier {turn[15:0], bunch} of the current count. After the capture the count advances: the bunch number counts 0 to BUNCH_COUNT-1, and a wrap returns it to 0 and adds one to the turn count.
- R3: When turnMark is high in a cycle where xingStb is high, the capture happens as normal. The bunch number then restarts at 0 and the turn count increments, whatever the bunch value was.
- R4: An accept (accStb high) is compared with the identifier captured LAT_DEPTH crossing strobes earlier, where the most recent strobe counts as one. A strobe in the same cycle as the accept does not shift before the comparison. accNum bits [23:8] carry the turn field and bits [7:0] carry the bunch field.
- R5: An accept that arrives before LAT_DEPTH crossing strobes have been seen since reset is not checked and changes no output.
- R6: A mismatching accept drives errPulse high for exactly the next clock cycle.
- R7: errSticky sets together with errPulse and stays set until clearErr is high. If clearErr and a new mismatch occur in the same cycle, the flag stays set.
- R8: On a mismatch, expSeen takes the expected identifier and gotSeen takes accNum, both in the same cycle as errPulse. Otherwise both hold their values.
- R9: An accept whose number matches the expected identifier leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xingStb | input | 1 | One-cycle strobe per beam crossing |
| turnMark | input | 1 | Start-of-turn marker, qualified by xingStb |
| accStb | input | 1 | Level-1 accept strobe |
| accNum | input | 24 | Composite accept number: turn[15:0], bunch[7:0] |
| clearErr | input | 1 | Clears the sticky error flag |
| errPulse | output | 1 | One-cycle mismatch indication |
| errSticky | output | 1 | Sticky mismatch flag |
| expSeen | output | 24 | Expected identifier of the last mismatch |
| gotSeen | output | 24 | Received accept number of the last mismatch |

## Verification
The assertions assume that every input is a clean, synchronous level sampled once per clock. They also assume that accNum is meaningful only in cycles where accStb is high, so a pulse always traces back to an accept one cycle earlier. The stimulus changes the inputs only just after a rising edge. It spaces crossing strobes irregularly and lets accepts fall both on strobe cycles and between them, so the compare-before-shift ordering is exercised. Correct accept numbers come from the bench's own queue of past crossings, and wrong numbers are formed from them by flipping bits or by stepping one crossing off.

// File: rtl/xsync_pkg.sv
package xsync_pkg;
  typedef struct packed {
    logic shiftEn;  // a crossing occurred: capture and advance
    logic resync;   // turn marker qualified by a crossing
    logic compare;  // accept that must be checked
    logic clear;    // clear the sticky flag
  } xsyncCtl_t;
endpackage

// File: rtl/xsync_ctrl.sv
module xsync_ctrl
  import xsync_pkg::*;
#(
  parameter int LAT_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      xingStb,
  input  logic      turnMark,
  input  logic      accStb,
  input  logic      clearErr,
  output xsyncCtl_t ctl
);
  localparam int FILL_W = $clog2(LAT_DEPTH + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(LAT_DEPTH);

  logic [FILL_W-1:0] fillCnt;
  logic              pipeFull;

  assign pipeFull = (fillCnt == FILL_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (xingStb && !pipeFull) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    ctl.shiftEn = xingStb;
    ctl.resync  = xingStb && turnMark;
    ctl.compare = accStb && pipeFull;
    ctl.clear   = clearErr;
  end
endmodule

// File: rtl/xsync_datapath.sv
module xsync_datapath
  import xsync_pkg::*;
#(
  parameter int LAT_DEPTH   = 4,
  parameter int BUNCH_COUNT = 36,
  parameter int BUNCH_W     = 8,
  parameter int TURN_W      = 32,
  parameter int ACC_TURN_W  = 16,
  localparam int ID_W       = ACC_TURN_W + BUNCH_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  xsyncCtl_t       ctl,
  input  logic [ID_W-1:0] accNum,
  output logic            errPulse,
  output logic            errSticky,
  output logic [ID_W-1:0] expSeen,
  output logic [ID_W-1:0] gotSeen
);
  localparam logic [BUNCH_W-1:0] LAST_BUNCH = BUNCH_W'(BUNCH_COUNT - 1);

  logic [TURN_W-1:0]  turnCnt;
  logic [BUNCH_W-1:0] bunchCnt;
  logic [ID_W-1:0]    curId;
  logic [ID_W-1:0]    pipe [LAT_DEPTH];
  logic               mismatch;

  // local crossing counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      turnCnt  <= '0;
      bunchCnt <= '0;
    end else if (ctl.shiftEn) begin
      if (ctl.resync || bunchCnt == LAST_BUNCH) begin
        bunchCnt <= '0;
        turnCnt  <= turnCnt + 1'b1;
      end else begin
        bunchCnt <= bunchCnt + 1'b1;
      end
    end
  end

  assign curId = {turnCnt[ACC_TURN_W-1:0], bunchCnt};

  // latency pipeline, one stage per crossing
  genvar g;
  generate
    for (g = 0; g < LAT_DEPTH; g++) begin : gStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipe[g] <= '0;
        end else if (ctl.shiftEn) begin
          if (g == 0) pipe[g] <= curId;
          else        pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign mismatch = ctl.compare && (accNum != pipe[LAT_DEPTH-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse  <= 1'b0;
      errSticky <= 1'b0;
      expSeen   <= '0;
      gotSeen   <= '0;
    end else begin
      errPulse <= mismatch;
      if (mismatch)       errSticky <= 1'b1;
      else if (ctl.clear) errSticky <= 1'b0;
      if (mismatch) begin
        expSeen <= pipe[LAT_DEPTH-1];
        gotSeen <= accNum;
      end
    end
  end
endmodule

// File: rtl/xsync_checker.sv
module xsync_checker
  import xsync_pkg::*;
#(
  parameter int LAT_DEPTH   = 4,
  parameter int BUNCH_COUNT = 36,
  parameter int BUNCH_W     = 8,
  parameter int TURN_W      = 32,
  parameter int ACC_TURN_W  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        xingStb,
  input  logic        turnMark,
  input  logic        accStb,
  input  logic [23:0] accNum,
  input  logic        clearErr,
  output logic        errPulse,
  output logic        errSticky,
  output logic [23:0] expSeen,
  output logic [23:0] gotSeen
);
  xsyncCtl_t ctl;

  xsync_ctrl #(.LAT_DEPTH(LAT_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .xingStb(xingStb), .turnMark(turnMark),
    .accStb(accStb), .clearErr(clearErr), .ctl(ctl)
  );

  xsync_datapath #(
    .LAT_DEPTH(LAT_DEPTH), .BUNCH_COUNT(BUNCH_COUNT), .BUNCH_W(BUNCH_W),
    .TURN_W(TURN_W), .ACC_TURN_W(ACC_TURN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .accNum(accNum),
    .errPulse(errPulse), .errSticky(errSticky),
    .expSeen(expSeen), .gotSeen(gotSeen)
  );
endmodule

// File: rtl/xsync_checker_sva.sv
module xsync_checker_sva (
  input logic        clk,
  input logic        rstN,
  input logic        accStb,
  input logic [23:0] accNum,
  input logic        clearErr,
  input logic        errPulse,
  input logic        errSticky,
  input logic [23:0] expSeen,
  input logic [23:0] gotSeen
);
  assert_pulse_needs_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(accStb));

  assert_sticky_with_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> errSticky);

  assert_sticky_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (errSticky && !clearErr) |=> errSticky);

  assert_pair_differs_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (expSeen != gotSeen));

  assert_got_is_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (gotSeen == $past(accNum)));

  assert_pair_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !errPulse |-> ($stable(expSeen) && $stable(gotSeen)));
endmodule

bind xsync_checker xsync_checker_sva chk_i (
  .clk(clk), .rstN(rstN), .accStb(accStb), .accNum(accNum),
  .clearErr(clearErr), .errPulse(errPulse), .errSticky(errSticky),
  .expSeen(expSeen), .gotSeen(gotSeen)
);

// File: tb/xsync_checker_tb.sv
module xsync_checker_tb_top;
  localparam int D  = 3;
  localparam int NB = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xingStb = 1'b0, turnMark = 1'b0, accStb = 1'b0, clearErr = 1'b0;
  logic [23:0] accNum = '0;
  logic        errPulse, errSticky;
  logic [23:0] expSeen, gotSeen;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  logic [23:0] q[$];
  int          turnM = 0, bunchM = 0;
  logic        mPulse = 0, mSticky = 0;
  logic [23:0] mExp = '0, mGot = '0;

  always #2.5 clk = ~clk;

  xsync_checker #(.LAT_DEPTH(D), .BUNCH_COUNT(NB)) dut_i (
    .clk(clk), .rstN(rstN), .xingStb(xingStb), .turnMark(turnMark),
    .accStb(accStb), .accNum(accNum), .clearErr(clearErr),
    .errPulse(errPulse), .errSticky(errSticky),
    .expSeen(expSeen), .gotSeen(gotSeen)
  );

  function automatic logic [23:0] expAcc();
    return (q.size() >= D) ? q[D-1] : 24'h0;
  endfunction

  task automatic chk(string what, logic [23:0] act, logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("errPulse", {23'b0, errPulse}, {23'b0, mPulse});
    chk("errSticky", {23'b0, errSticky}, {23'b0, mSticky});
    chk("expSeen", expSeen, mExp);
    chk("gotSeen", gotSeen, mGot);
  endtask

  task automatic modelStep();
    logic mis;
    mis = accStb && (q.size() >= D) && (q[D-1] != accNum);
    if (xingStb) begin
      q.push_front({turnM[15:0], bunchM[7:0]});
      if (q.size() > D) void'(q.pop_back());
      if (turnMark || bunchM == NB - 1) begin
        bunchM = 0;
        turnM++;
      end else bunchM++;
    end
    mPulse = mis;
    if (mis) begin
      mSticky = 1;
      mExp = q.size() >= D ? mExp : mExp;
    end else if (clearErr) mSticky = 0;
  endtask

  task automatic cyc(bit x, bit tm, bit a, logic [23:0] n, bit c);
    logic [23:0] e;
    xingStb = x; turnMark = tm; accStb = a; accNum = n; clearErr = c;
    e = expAcc();
    @(posedge clk);
    if (a && q.size() >= D && e != n) begin
      mExp = e;
      mGot = n;
    end
    modelStep();
    #1;
    compareAll();
  endtask

  // accept with the correct number, optionally on a strobe cycle
  task automatic goodAcc(bit x);
    cyc(x, 0, 1, expAcc(), 0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #1;
    phase = "R1";
    compareAll();
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0);

    phase = "R5";  // accepts before the pipeline holds D crossings
    cyc(0, 0, 1, 24'hABCDEF, 0);
    cyc(1, 0, 1, 24'h123456, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 24'h00FF00, 0);

    phase = "R4";  // third strobe fills; accept same cycle still unchecked
    cyc(1, 0, 1, 24'h777777, 0);
    goodAcc(0);
    goodAcc(1);
    cyc(0, 0, 0, 0, 0);
    goodAcc(0);

    phase = "R2";  // run through several bunch wraps
    for (int i = 0; i < 14; i++) begin
      cyc(1, 0, 0, 0, 0);
      if (i % 3 == 0) goodAcc(0);
    end
    goodAcc(1);

    phase = "R9";
    for (int i = 0; i < 4; i++) goodAcc(i % 2);

    phase = "R6";
    cyc(0, 0, 1, expAcc() ^ 24'h000100, 0);
    cyc(0, 0, 0, 0, 0);

    phase = "R8";  // off by one crossing, on a strobe cycle
    cyc(1, 0, 1, q[D-2], 0);
    cyc(1, 0, 1, expAcc() ^ 24'h000001, 0);
    goodAcc(0);

    phase = "R7";
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, expAcc() ^ 24'h800000, 1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);

    phase = "R3";  // turn marker mid-turn
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      cyc(1, 0, 0, 0, 0);
      goodAcc(0);
    end
    cyc(1, 1, 1, expAcc(), 0);
    cyc(1, 0, 1, expAcc() ^ 24'h010000, 0);
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule